// File: doc/BRIEF.md
# Strobed Handshake Parallel Port Pair

This block provides two byte-wide parallel ports, A and B, plus an eight-line auxiliary port C, all behind a small CPU register interface. The CPU can read a port, write a port, write the control register and read back port C as a status byte. A control word with its top bit set reconfigures the block. For each of two groups, it picks a strobed handshake mode or plain I/O, and it sets a direction. A control word with its top bit clear changes exactly one port C bit.

In handshake mode, an external device moves data into a port with an active-low strobe, or takes data out of it with an active-low acknowledge. The block exposes buffer-full flags and interrupt requests on fixed port C lines. Each port has one interrupt enable, and only single-bit commands can change it. A port C status read shows these flags, the enables and the state of the spare lines.

CPU accesses are single-cycle strobes with no back-pressure. A read returns data combinationally in the strobe cycle, a write takes effect at the clock edge that samples it, and nothing ever stalls. Handshake lines are sampled on the block clock, so each edge a device produces is seen one clock later.

Top module: `hs_port_pair`

## Requirements
- R1: After reset, all three ports are inputs. `pa_oe`, `pb_oe` and every `pc_oe` bit are 0, and a port C read returns the `pc_in` levels.
- R2: Writing address 3 with bit 7 = 1 sets the configuration. Bits 6:5 = 01 put group A in handshake mode, and any other value makes it plain. Bit 4 = 1 makes port A an input, and bit 3 = 1 makes the free upper port C lines inputs. Bit 2 = 1 puts group B in handshake mode. Bit 1 = 1 makes port B an input, and bit 0 = 1 makes the free lower port C lines inputs.
- R3: A configuration write clears the port output latches and the port C latch. It also clears both buffer-full-on-input flags, both interrupt requests and both interrupt enables. The output-buffer-full lines return high.
- R4: Writing address 3 with bit 7 = 0 loads bit value D0 into port C latch bit D3:D1. The latch drives a pin only when that line is a free output.
- R5: Only a single-bit command at a fixed position changes an interrupt enable. Port A's enable sits at position 4 when A is an input and at position 6 when A is an output. Port B's enable sits at position 2. A direct port C write leaves both enables unchanged.
- R6: In input handshake, STB is active low, on PC4 for port A and PC2 for port B. While STB is low, the port pins are latched and the buffer-full line goes high, on PC5 for A and PC1 for B.
- R7: On STB's rising edge, the interrupt request rises only if that port's enable is set. The request appears on PC3 for A and PC0 for B.
- R8: A CPU read of an input-handshake port clears its interrupt request at the edge of the read cycle. The buffer-full flag clears one edge later.
- R9: In output handshake, a CPU port write places the data on the port pins, drives the output-buffer-full line low and clears the interrupt request. That line is PC7 for A and PC1 for B.
- R10: In output handshake, ACK is active low, on PC6 for A and PC2 for B. ACK low returns output-buffer-full high, and ACK's rising edge raises the interrupt request only if the port's enable is set.
- R11: A port C read returns the status byte. Handshake line positions carry the flag levels, and the enable positions carry the enables. Free lines read their pin if they are inputs and their latch if they are outputs.
- R12: In plain mode, an input port reads its pins directly, and every port C line of that group follows its group direction bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 2 | 0 port A, 1 port B, 2 port C / status, 3 control |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid in the strobe cycle |
| pa_in | input | DW | Port A pin levels |
| pa_out | output | DW | Port A drive value |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | DW | Port B pin levels |
| pb_out | output | DW | Port B drive value |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin levels, including STB and ACK |
| pc_out | output | 8 | Port C drive values, including flags |
| pc_oe | output | 8 | Port C per-line drive enables |

## Verification
The hardest state to reach is a port with an interrupt request raised while its buffer-full flag is still high, followed by a read. In that read, the request must fall at once and the flag must fall one edge later. Reaching it takes a configuration write, then a single-bit command that sets the enable at the right position for the chosen direction, then a full strobe low-high pulse, and only then the read. The bench samples the port C lines after each of the next two edges. The same sequence is repeated with the enable cleared and with a direct port C write of all ones, which shows that the request stays low and that the enable can only be reached through the single-bit path.

// File: rtl/hs_port_pkg.sv
`timescale 1ns/1ps
package hs_port_pkg;

  localparam int PCW = 8;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } sel_e;

  typedef struct packed {
    logic a_hs;
    logic a_in;
    logic cu_in;
    logic b_hs;
    logic b_in;
    logic cl_in;
  } mode_t;

  localparam mode_t MODE_RESET = '{a_hs: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                   b_hs: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic mode_t decode_mode(input logic [7:0] w);
    mode_t m;
    m.a_hs  = (w[6:5] == 2'b01);
    m.a_in  = w[4];
    m.cu_in = w[3];
    m.b_hs  = w[2];
    m.b_in  = w[1];
    m.cl_in = w[0];
    return m;
  endfunction

endpackage

// File: rtl/hs_chan.sv
`timescale 1ns/1ps
module hs_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hs_en,
  input  logic          dir_in,
  input  logic          line_n,
  input  logic [DW-1:0] pin_d,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          inte,
  output logic [DW-1:0] data_q,
  output logic          ibf,
  output logic          obf_n,
  output logic          intr
);

  logic line_q;
  logic rd_q;
  logic line_rise;

  assign line_rise = hs_en & line_n & ~line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b1;
      rd_q   <= 1'b0;
      data_q <= '0;
      ibf    <= 1'b0;
      obf_n  <= 1'b1;
      intr   <= 1'b0;
    end else begin
      line_q <= line_n;
      rd_q   <= rd;
      if (clr) begin
        data_q <= '0;
        ibf    <= 1'b0;
        obf_n  <= 1'b1;
        intr   <= 1'b0;
      end else if (dir_in) begin
        // read clears, strobe sets; later assignment wins
        if (rd_q && !rd) ibf <= 1'b0;
        if (hs_en && !line_n) begin
          data_q <= pin_d;
          ibf    <= 1'b1;
        end
        if (rd) intr <= 1'b0;
        if (line_rise && inte) intr <= 1'b1;
      end else begin
        if (wr) begin
          data_q <= wdata;
          if (hs_en) begin
            obf_n <= 1'b0;
            intr  <= 1'b0;
          end
        end
        if (hs_en && !line_n) obf_n <= 1'b1;
        if (line_rise && inte) intr <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pc_map.sv
`timescale 1ns/1ps
module pc_map
  import hs_port_pkg::*;
(
  input  mode_t          m,
  input  logic [PCW-1:0] lat,
  input  logic [PCW-1:0] pin,
  input  logic           ibf_a,
  input  logic           obf_a_n,
  input  logic           intr_a,
  input  logic           inte_a,
  input  logic           ibf_b,
  input  logic           obf_b_n,
  input  logic           intr_b,
  input  logic           inte_b,
  output logic [PCW-1:0] pc_out,
  output logic [PCW-1:0] pc_oe,
  output logic [PCW-1:0] status
);

  localparam int HALF = PCW / 2;

  always_comb begin
    for (int i = 0; i < PCW; i++) begin
      pc_oe[i]  = (i >= HALF) ? ~m.cu_in : ~m.cl_in;
      pc_out[i] = lat[i];
      status[i] = pc_oe[i] ? lat[i] : pin[i];
    end

    if (m.b_hs) begin
      pc_oe[2]  = 1'b0;
      status[2] = inte_b;
      pc_oe[0]  = 1'b1;
      pc_out[0] = intr_b;
      status[0] = intr_b;
      pc_oe[1]  = 1'b1;
      pc_out[1] = m.b_in ? ibf_b : obf_b_n;
      status[1] = pc_out[1];
    end

    if (m.a_hs) begin
      pc_oe[3]  = 1'b1;
      pc_out[3] = intr_a;
      status[3] = intr_a;
      if (m.a_in) begin
        pc_oe[4]  = 1'b0;
        status[4] = inte_a;
        pc_oe[5]  = 1'b1;
        pc_out[5] = ibf_a;
        status[5] = ibf_a;
      end else begin
        pc_oe[6]  = 1'b0;
        status[6] = inte_a;
        pc_oe[7]  = 1'b1;
        pc_out[7] = obf_a_n;
        status[7] = obf_a_n;
      end
    end
  end

endmodule

// File: rtl/hs_port_pair.sv
`timescale 1ns/1ps
module hs_port_pair
  import hs_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cpu_addr,
  input  logic           cpu_rd,
  input  logic           cpu_wr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  input  logic [DW-1:0]  pa_in,
  output logic [DW-1:0]  pa_out,
  output logic           pa_oe,
  input  logic [DW-1:0]  pb_in,
  output logic [DW-1:0]  pb_out,
  output logic           pb_oe,
  input  logic [PCW-1:0] pc_in,
  output logic [PCW-1:0] pc_out,
  output logic [PCW-1:0] pc_oe
);

  mode_t          mode;
  logic [PCW-1:0] pc_lat;
  logic           inte_a, inte_b;
  logic           a_hs, a_in;
  logic           ctl_wr, mode_wr, bit_wr, pc_wr;
  logic [2:0]     bit_idx;
  logic           bit_val;
  logic [DW-1:0]  a_data, b_data;
  logic           ibf_a, obf_a_n, intr_a;
  logic           ibf_b, obf_b_n, intr_b;
  logic           a_line_n;
  logic [PCW-1:0] status;

  assign a_hs    = mode.a_hs;
  assign a_in    = mode.a_in;
  assign ctl_wr  = cpu_wr && (sel_e'(cpu_addr) == SEL_CTL);
  assign mode_wr = ctl_wr && cpu_wdata[7];
  assign bit_wr  = ctl_wr && !cpu_wdata[7];
  assign pc_wr   = cpu_wr && (sel_e'(cpu_addr) == SEL_C);
  assign bit_idx = cpu_wdata[3:1];
  assign bit_val = cpu_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_RESET;
      pc_lat <= '0;
      inte_a <= 1'b0;
      inte_b <= 1'b0;
    end else if (mode_wr) begin
      mode   <= decode_mode(cpu_wdata[7:0]);
      pc_lat <= '0;
      inte_a <= 1'b0;
      inte_b <= 1'b0;
    end else if (bit_wr) begin
      pc_lat[bit_idx] <= bit_val;
      if (mode.a_hs && (bit_idx == (mode.a_in ? 3'd4 : 3'd6))) inte_a <= bit_val;
      if (mode.b_hs && (bit_idx == 3'd2))                      inte_b <= bit_val;
    end else if (pc_wr) begin
      pc_lat <= cpu_wdata[PCW-1:0];
    end
  end

  assign a_line_n = mode.a_in ? pc_in[4] : pc_in[6];

  hs_chan #(.DW(DW)) u_chan_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (mode_wr),
    .hs_en  (mode.a_hs),
    .dir_in (mode.a_in),
    .line_n (a_line_n),
    .pin_d  (pa_in),
    .rd     (cpu_rd && (sel_e'(cpu_addr) == SEL_A)),
    .wr     (cpu_wr && (sel_e'(cpu_addr) == SEL_A)),
    .wdata  (cpu_wdata),
    .inte   (inte_a),
    .data_q (a_data),
    .ibf    (ibf_a),
    .obf_n  (obf_a_n),
    .intr   (intr_a)
  );

  hs_chan #(.DW(DW)) u_chan_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (mode_wr),
    .hs_en  (mode.b_hs),
    .dir_in (mode.b_in),
    .line_n (pc_in[2]),
    .pin_d  (pb_in),
    .rd     (cpu_rd && (sel_e'(cpu_addr) == SEL_B)),
    .wr     (cpu_wr && (sel_e'(cpu_addr) == SEL_B)),
    .wdata  (cpu_wdata),
    .inte   (inte_b),
    .data_q (b_data),
    .ibf    (ibf_b),
    .obf_n  (obf_b_n),
    .intr   (intr_b)
  );

  pc_map u_pc_map (
    .m       (mode),
    .lat     (pc_lat),
    .pin     (pc_in),
    .ibf_a   (ibf_a),
    .obf_a_n (obf_a_n),
    .intr_a  (intr_a),
    .inte_a  (inte_a),
    .ibf_b   (ibf_b),
    .obf_b_n (obf_b_n),
    .intr_b  (intr_b),
    .inte_b  (inte_b),
    .pc_out  (pc_out),
    .pc_oe   (pc_oe),
    .status  (status)
  );

  assign pa_out = a_data;
  assign pa_oe  = ~mode.a_in;
  assign pb_out = b_data;
  assign pb_oe  = ~mode.b_in;

  always_comb begin
    unique case (sel_e'(cpu_addr))
      SEL_A:   cpu_rdata = (mode.a_in && !mode.a_hs) ? pa_in : a_data;
      SEL_B:   cpu_rdata = (mode.b_in && !mode.b_hs) ? pb_in : b_data;
      SEL_C:   cpu_rdata = DW'(status);
      default: cpu_rdata = '0;
    endcase
  end

endmodule

// File: rtl/hs_port_pair_chk.sv
`timescale 1ns/1ps
module hs_port_pair_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cpu_addr,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic [DW-1:0] cpu_wdata,
  input logic          a_hs,
  input logic          a_in,
  input logic          inte_a,
  input logic          inte_b,
  input logic          ibf_a,
  input logic          obf_a_n,
  input logic          intr_a,
  input logic          ibf_b,
  input logic          obf_b_n,
  input logic          intr_b,
  input logic [7:0]    pc_in,
  input logic [7:0]    pc_oe,
  input logic [DW-1:0] pa_out
);

  // R3: a configuration write clears flags and enables
  assert_mode_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 2'd3 && cpu_wdata[7]) |=>
      (!intr_a && !intr_b && !ibf_a && !ibf_b && obf_a_n && obf_b_n && !inte_a && !inte_b));

  // R2: port A strobe line is never driven in input handshake
  assert_stb_not_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hs && a_in) |-> !pc_oe[4]);

  // R7: with the enable clear, the request cannot rise
  assert_intr_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hs && a_in && !inte_a && !intr_a) |=> !intr_a);

  // R8: a port read drops the request once the enable is clear
  assert_read_clears_intr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hs && a_in && !inte_a && cpu_rd && cpu_addr == 2'd0) |=> !intr_a);

  // R9: output write fills the buffer and drives the data
  assert_write_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hs && !a_in && cpu_wr && cpu_addr == 2'd0 && pc_in[6]) |=>
      (!obf_a_n && pa_out == $past(cpu_wdata)));

  // R10: acknowledge empties the buffer
  assert_ack_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hs && !a_in && !pc_in[6]) |=> obf_a_n);

endmodule

bind hs_port_pair hs_port_pair_chk #(.DW(DW)) u_hs_port_pair_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_wdata (cpu_wdata),
  .a_hs      (a_hs),
  .a_in      (a_in),
  .inte_a    (inte_a),
  .inte_b    (inte_b),
  .ibf_a     (ibf_a),
  .obf_a_n   (obf_a_n),
  .intr_a    (intr_a),
  .ibf_b     (ibf_b),
  .obf_b_n   (obf_b_n),
  .intr_b    (intr_b),
  .pc_in     (pc_in),
  .pc_oe     (pc_oe),
  .pa_out    (pa_out)
);

// File: tb/test_hs_port_pair.sv
`timescale 1ns/1ps
module test_hs_port_pair;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic       cpu_rd = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic [7:0] pa_in = 8'h00, pa_out;
  logic       pa_oe;
  logic [7:0] pb_in = 8'h00, pb_out;
  logic       pb_oe;
  logic [7:0] pc_in = 8'hFF, pc_out, pc_oe;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  hs_port_pair i_hs_port_pair (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    d = cpu_rdata;
    tick();
    cpu_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pa_oe", {7'd0, pa_oe}, 8'h00);
    chk("R1 pb_oe", {7'd0, pb_oe}, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    pc_in = 8'h5A;
    rd_reg(2'd2, v);
    chk("R1 port C pins", v, 8'h5A);
    pa_in = 8'hC7;
    rd_reg(2'd0, v);
    chk("R12 plain A reads pins", v, 8'hC7);
    pc_in = 8'hFF;
  endtask

  task automatic t_mode_decode();
    wr_reg(2'd3, 8'hA6);
    chk("R2 pc_oe A out/B in", pc_oe, 8'hBB);
    chk("R2 pa_oe", {7'd0, pa_oe}, 8'h01);
    chk("R2 pb_oe", {7'd0, pb_oe}, 8'h00);
    chk("R3 OBF_A idle high", {7'd0, pc_out[7]}, 8'h01);
    wr_reg(2'd3, 8'hB9);
    chk("R2 pc_oe A in/B plain", pc_oe, 8'h28);
    chk("R2 pb_oe plain out", {7'd0, pb_oe}, 8'h01);
  endtask

  task automatic t_input_a();
    logic [7:0] v;
    wr_reg(2'd3, 8'hB6);
    wr_reg(2'd3, 8'h09);
    wr_reg(2'd3, 8'h05);
    wr_reg(2'd3, 8'h0F);
    chk("R4 free PC7 driven", {6'd0, pc_oe[7], pc_out[7]}, 8'h03);
    rd_reg(2'd2, v);
    chk("R11 input status idle", v, 8'h94);
    pa_in = 8'h3C; pc_in[4] = 1'b0;
    tick();
    chk("R6 IBF_A high", {7'd0, pc_out[5]}, 8'h01);
    chk("R7 INTR_A low while STB low", {7'd0, pc_out[3]}, 8'h00);
    pc_in[4] = 1'b1;
    tick();
    pa_in = 8'h00;
    chk("R7 INTR_A on STB rise", {7'd0, pc_out[3]}, 8'h01);
    rd_reg(2'd2, v);
    chk("R11 input status full", v, 8'hBC);
    rd_reg(2'd0, v);
    chk("R6 latched data", v, 8'h3C);
    chk("R8 INTR_A cleared at read", {7'd0, pc_out[3]}, 8'h00);
    chk("R8 IBF_A still high", {7'd0, pc_out[5]}, 8'h01);
    tick();
    chk("R8 IBF_A cleared after read", {7'd0, pc_out[5]}, 8'h00);
  endtask

  task automatic t_inte_gate();
    logic [7:0] v;
    wr_reg(2'd3, 8'h08);
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd2, v);
    chk("R5 port C write leaves INTE_A", {7'd0, v[4]}, 8'h00);
    pa_in = 8'h21; pc_in[4] = 1'b0;
    tick();
    pc_in[4] = 1'b1;
    tick();
    chk("R7 no INTR_A with INTE clear", {7'd0, pc_out[3]}, 8'h00);
    chk("R6 IBF_A set without INTE", {7'd0, pc_out[5]}, 8'h01);
    rd_reg(2'd0, v);
    tick();
  endtask

  task automatic t_input_b();
    logic [7:0] v;
    pb_in = 8'hC3; pc_in[2] = 1'b0;
    tick();
    chk("R6 IBF_B high", {7'd0, pc_out[1]}, 8'h01);
    pc_in[2] = 1'b1;
    tick();
    pb_in = 8'h00;
    chk("R7 INTR_B on STB rise", {7'd0, pc_out[0]}, 8'h01);
    rd_reg(2'd1, v);
    chk("R6 port B latched", v, 8'hC3);
    chk("R8 INTR_B cleared", {7'd0, pc_out[0]}, 8'h00);
  endtask

  task automatic t_output();
    logic [7:0] v;
    wr_reg(2'd3, 8'hA4);
    chk("R3 OBF lines high", {6'd0, pc_out[7], pc_out[1]}, 8'h03);
    wr_reg(2'd3, 8'h0D);
    wr_reg(2'd3, 8'h05);
    wr_reg(2'd0, 8'h77);
    chk("R9 port A drives data", pa_out, 8'h77);
    chk("R9 OBF_A low", {7'd0, pc_out[7]}, 8'h00);
    rd_reg(2'd2, v);
    chk("R11 output status", v, 8'h46);
    pc_in[6] = 1'b0;
    tick();
    chk("R10 ACK releases OBF_A", {7'd0, pc_out[7]}, 8'h01);
    chk("R10 no INTR_A while ACK low", {7'd0, pc_out[3]}, 8'h00);
    pc_in[6] = 1'b1;
    tick();
    chk("R10 INTR_A on ACK rise", {7'd0, pc_out[3]}, 8'h01);
    wr_reg(2'd0, 8'h11);
    chk("R9 write clears INTR_A", {6'd0, pc_out[3], pc_out[7]}, 8'h00);
    wr_reg(2'd1, 8'h99);
    chk("R9 port B drives data", pb_out, 8'h99);
    chk("R9 OBF_B low", {7'd0, pc_out[1]}, 8'h00);
    pc_in[2] = 1'b0;
    tick();
    chk("R10 ACK releases OBF_B", {7'd0, pc_out[1]}, 8'h01);
    pc_in[2] = 1'b1;
    tick();
    chk("R10 INTR_B on ACK rise", {7'd0, pc_out[0]}, 8'h01);
  endtask

  task automatic t_modeset_clear();
    logic [7:0] v;
    wr_reg(2'd3, 8'hA4);
    chk("R3 latch A cleared", pa_out, 8'h00);
    chk("R3 INTR lines low", {6'd0, pc_out[3], pc_out[0]}, 8'h00);
    rd_reg(2'd2, v);
    chk("R3 status after reconfigure", v, 8'h82);
  endtask

  task automatic t_plain();
    logic [7:0] v;
    wr_reg(2'd3, 8'h80);
    chk("R12 all C outputs", pc_oe, 8'hFF);
    wr_reg(2'd2, 8'hA5);
    chk("R12 port C latch drives", pc_out, 8'hA5);
    rd_reg(2'd2, v);
    chk("R11 output lines read latch", v, 8'hA5);
    wr_reg(2'd3, 8'h9B);
    pb_in = 8'h6E;
    rd_reg(2'd1, v);
    chk("R12 plain B reads pins", v, 8'h6E);
    chk("R12 all C inputs", pc_oe, 8'h00);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mode_decode();
    t_input_a();
    t_inte_gate();
    t_input_b();
    t_output();
    t_modeset_clear();
    t_plain();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule